// File: doc/BRIEF.md
# Programmable Square-Wave Clock Generator

This block synthesises a square wave from a 16-bit tuning word and one of eight reference rates. The reference rates are derived from the system clock by powers of two. A 3-bit select `k` sets the divider, so the accumulator advances once every 2^k system clocks. The nominal system clock is 20 MHz, which gives reference rates from 20 MHz down to 156.25 kHz. On each advance, a 16-bit phase accumulator adds the tuning word. The most significant bit of the accumulator is the output. The output frequency is therefore tuning / 65536 times the selected reference rate.

A host writes the tuning word and the select in one cycle. Each write restarts the accumulator and the divider from zero, so the phase of the output is known after every write. A separate off control stops the generator, forces the output low and clears the phase. Both settings remain readable at all times: the tuning word, the select and the selected reference rate in hertz. The square wave reaches only the output pins whose bit in the clock-mode mask is set. All other pins stay low.

Top module: `sqwave_synth`

## Requirements
- R1: After reset the output pins are all low, `rd_running` is 0, `rd_tune` is 0, `rd_sel` is 0 and `rd_ref_hz` equals the base rate (20000000).
- R2: With select `k`, the accumulator advances exactly once every 2^k system clocks. `rd_ref_hz` reads 20000000 >> k: 20 MHz for k=0 and 156250 for k=7.
- R3: For a tuning word of at most 32768, count the rising edges of the output over the N clocks that follow a configuration write. The count equals floor((E*tune + 32768) / 65536), where E = floor(N / 2^k) is the number of advances.
- R4: A tuning word of 0 keeps the output permanently low while the generator runs.
- R5: A configuration write clears the accumulator and the divider phase. A rewrite during operation therefore gives the same edge count as a write from reset.
- R6: When `off_req` is high at a clock edge, the output is low from that edge on, `rd_running` drops to 0 and the accumulator is cleared. The stored tuning word and select stay readable. The output stays low until the next write.
- R7: When `off_req` and `cfg_we` are both high at the same edge, the off request wins and the write is discarded: the read-back values do not change.
- R8: After a write edge, `rd_tune` and `rd_sel` show the written values and `rd_running` is 1.
- R9: Output pin i carries the wave only when `pin_clk_mode[i]` is 1; a pin whose mask bit is 0 stays low.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (nominally 20 MHz) |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write strobe for tuning word and select |
| cfg_tune | input | 16 | Tuning word, 0..65535 |
| cfg_sel | input | 3 | Reference select k, rate = base / 2^k |
| off_req | input | 1 | Stop generator, clear phase, output low |
| pin_clk_mode | input | NUM_PINS | Per-pin clock-mode enable |
| rd_tune | output | 16 | Stored tuning word |
| rd_sel | output | 3 | Stored reference select |
| rd_ref_hz | output | 25 | Selected reference rate in Hz |
| rd_running | output | 1 | Generator active |
| wave_pins | output | NUM_PINS | Square wave on pins in clock mode |

## Verification
The bench counts rising edges over fixed windows and compares each count with the closed-form formula. It covers the fastest and slowest selects and a tuning word of exactly half scale. A divider that was off by one in its enable spacing, or that skipped its first advance, would miss these counts by one or more edges. A rewrite is made mid-run from a deliberately non-zero phase. A design that failed to clear the accumulator would produce an extra or a missing edge in that case. The off request is checked alone and together with a write, as are a zero tuning word and a partial pin mask. Under those tests, a generator that kept toggling, stored the discarded write, or leaked the wave to unmasked pins shows up directly at the ports.

// File: rtl/sqgen_pkg.sv
package sqgen_pkg;

  parameter int unsigned SEL_W = 3;
  localparam int unsigned DIV_W = (1 << SEL_W) - 1;

  // Reference rate in Hz for a divide-by-2^sel of the base clock
  function automatic int unsigned ref_rate(input int unsigned base_hz,
                                           input logic [SEL_W-1:0] sel);
    return base_hz >> sel;
  endfunction

  // Low-order ones mask: an enable fires when the divider count matches it
  function automatic logic [DIV_W-1:0] div_mask(input logic [SEL_W-1:0] sel);
    logic [DIV_W-1:0] m;
    m = '0;
    for (int i = 0; i < DIV_W; i++) begin
      if (i < int'(sel)) m[i] = 1'b1;
    end
    return m;
  endfunction

endpackage

// File: rtl/sqgen_prescale.sv
module sqgen_prescale
  import sqgen_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             run,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);

  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] mask;

  assign mask = div_mask(sel);
  assign tick = run && ((cnt_q & mask) == mask);

  always_ff @(posedge clk) begin
    if (!rst_n)                cnt_q <= '0;
    else if (restart || !run)  cnt_q <= '0;
    else                       cnt_q <= cnt_q + 1'b1;
  end

  // R2: with k > 0 two enables are never adjacent
  a_r2_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && sel != '0 && !restart) |=> !tick);

endmodule

// File: rtl/sqgen_accum.sv
module sqgen_accum #(
  parameter int unsigned TUNE_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              step,
  input  logic [TUNE_W-1:0] tune,
  output logic              msb
);

  logic [TUNE_W-1:0] acc_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      acc_q <= '0;
    else if (clear)  acc_q <= '0;
    else if (step)   acc_q <= acc_q + tune;
  end

  assign msb = acc_q[TUNE_W-1];

  // R4: a zero tuning word never lifts the output
  a_r4_zero_tune_low: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && tune == '0 && !msb) |=> !msb);

endmodule

// File: rtl/sqgen_pinmux.sv
module sqgen_pinmux #(
  parameter int unsigned NUM_PINS = 4
) (
  input  logic                wave,
  input  logic [NUM_PINS-1:0] clk_mode,
  output logic [NUM_PINS-1:0] pins
);

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    assign pins[i] = wave & clk_mode[i];
  end

endmodule

// File: rtl/sqwave_synth.sv
module sqwave_synth
  import sqgen_pkg::*;
#(
  parameter int unsigned NUM_PINS = 4,
  parameter int unsigned BASE_HZ  = 20_000_000,
  parameter int unsigned TUNE_W   = 16,
  localparam int unsigned REF_W   = $clog2(BASE_HZ + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [TUNE_W-1:0]   cfg_tune,
  input  logic [SEL_W-1:0]    cfg_sel,
  input  logic                off_req,
  input  logic [NUM_PINS-1:0] pin_clk_mode,
  output logic [TUNE_W-1:0]   rd_tune,
  output logic [SEL_W-1:0]    rd_sel,
  output logic [REF_W-1:0]    rd_ref_hz,
  output logic                rd_running,
  output logic [NUM_PINS-1:0] wave_pins
);

  logic [TUNE_W-1:0] tune_q;
  logic [SEL_W-1:0]  sel_q;
  logic              running_q;

  // Named internal events
  logic wr_take;
  logic restart;
  logic adv_tick;
  logic acc_msb;
  logic wave;

  assign wr_take = cfg_we && !off_req;
  assign restart = wr_take || off_req;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tune_q    <= '0;
      sel_q     <= '0;
      running_q <= 1'b0;
    end else if (off_req) begin
      running_q <= 1'b0;
    end else if (cfg_we) begin
      tune_q    <= cfg_tune;
      sel_q     <= cfg_sel;
      running_q <= 1'b1;
    end
  end

  sqgen_prescale u_prescale (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (restart),
    .run     (running_q),
    .sel     (sel_q),
    .tick    (adv_tick)
  );

  sqgen_accum #(.TUNE_W(TUNE_W)) u_accum (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (restart || !running_q),
    .step  (adv_tick),
    .tune  (tune_q),
    .msb   (acc_msb)
  );

  assign wave = acc_msb && running_q;

  sqgen_pinmux #(.NUM_PINS(NUM_PINS)) u_pinmux (
    .wave     (wave),
    .clk_mode (pin_clk_mode),
    .pins     (wave_pins)
  );

  assign rd_tune    = tune_q;
  assign rd_sel     = sel_q;
  assign rd_ref_hz  = REF_W'(ref_rate(BASE_HZ, sel_q));
  assign rd_running = running_q;

  // R6: off silences all pins and clears the running flag at the next edge
  a_r6_off_silences: assert property (@(posedge clk) disable iff (!rst_n)
    off_req |=> (wave_pins == '0 && !rd_running));

  // R7: a write colliding with off is discarded
  a_r7_off_beats_write: assert property (@(posedge clk) disable iff (!rst_n)
    (off_req && cfg_we) |=> ($stable(rd_tune) && $stable(rd_sel)));

  // R8: accepted write is visible at the next edge
  a_r8_readback: assert property (@(posedge clk) disable iff (!rst_n)
    wr_take |=> (rd_tune == $past(cfg_tune) && rd_sel == $past(cfg_sel) && rd_running));

  // R5: a write restarts the phase, so the wave is low just after it
  a_r5_write_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    wr_take |=> (wave_pins == '0));

endmodule

// File: tb/sqwave_synth_tb.sv
module sqwave_synth_tb;

  localparam int NP = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cfg_we;
  logic [15:0]   cfg_tune;
  logic [2:0]    cfg_sel;
  logic          off_req;
  logic [NP-1:0] pin_clk_mode;
  logic [15:0]   rd_tune;
  logic [2:0]    rd_sel;
  logic [24:0]   rd_ref_hz;
  logic          rd_running;
  logic [NP-1:0] wave_pins;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  sqwave_synth #(.NUM_PINS(NP)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_tune(cfg_tune),
    .cfg_sel(cfg_sel), .off_req(off_req), .pin_clk_mode(pin_clk_mode),
    .rd_tune(rd_tune), .rd_sel(rd_sel), .rd_ref_hz(rd_ref_hz),
    .rd_running(rd_running), .wave_pins(wave_pins)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic longint expect_edges(input int n, input int k, input int tune);
    longint adv, total;
    adv   = longint'(n / (1 << k));
    total = adv * tune;
    return (total + 32768) / 65536;
  endfunction

  task automatic write_cfg(input int tune, input int k);
    @(negedge clk);
    cfg_we = 1'b1; cfg_tune = 16'(tune); cfg_sel = 3'(k);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // Counts rises on pin 0 and mask leaks over n clocks
  task automatic measure(input int n, output int rises, output int leaks);
    logic prev;
    prev = 1'b0; rises = 0; leaks = 0;
    repeat (n) begin
      @(negedge clk);
      if (wave_pins[0] && !prev) rises++;
      prev = wave_pins[0];
      if (wave_pins[1] || wave_pins[3] || (wave_pins[2] != wave_pins[0])) leaks++;
    end
  endtask

  task automatic t_reset;
    chk(wave_pins == '0, "R1", "pins after reset", wave_pins, 0);
    chk(!rd_running, "R1", "running after reset", rd_running, 0);
    chk(rd_tune == 0 && rd_sel == 0, "R1", "readback after reset", rd_tune, 0);
    chk(rd_ref_hz == 20000000, "R1", "ref after reset", rd_ref_hz, 20000000);
  endtask

  task automatic t_freq(input int tune, input int k, input int n);
    int r, lk;
    longint e;
    write_cfg(tune, k);
    chk(rd_tune == 16'(tune) && rd_sel == 3'(k) && rd_running, "R8", "readback tune",
        rd_tune, tune);
    chk(rd_ref_hz == 25'(20000000 / (1 << k)), "R2", "ref rate", rd_ref_hz,
        20000000 / (1 << k));
    measure(n, r, lk);
    e = expect_edges(n, k, tune);
    chk(longint'(r) == e, "R3", "edge count", r, e);
    chk(lk == 0, "R9", "mask leaks", lk, 0);
  endtask

  task automatic t_zero;
    int r, lk, highs;
    write_cfg(0, 0);
    highs = 0;
    repeat (2000) begin
      @(negedge clk);
      if (wave_pins != '0) highs++;
    end
    chk(highs == 0, "R4", "zero tune high samples", highs, 0);
    measure(10, r, lk);
    chk(r == 0, "R4", "zero tune edges", r, 0);
  endtask

  task automatic t_rewrite;
    int r, lk;
    longint e;
    write_cfg(3000, 0);
    repeat (37) @(negedge clk);   // leave a non-zero phase behind
    write_cfg(3000, 0);
    measure(4096, r, lk);
    e = expect_edges(4096, 0, 3000);
    chk(longint'(r) == e, "R5", "edges after rewrite", r, e);
  endtask

  task automatic t_off;
    int highs;
    write_cfg(20000, 0);
    repeat (50) @(negedge clk);
    off_req = 1'b1;
    @(negedge clk);
    off_req = 1'b0;
    chk(!rd_running, "R6", "running after off", rd_running, 0);
    chk(rd_tune == 20000 && rd_sel == 0, "R6", "kept tune", rd_tune, 20000);
    highs = 0;
    repeat (300) begin
      @(negedge clk);
      if (wave_pins != '0) highs++;
    end
    chk(highs == 0, "R6", "high samples while off", highs, 0);
  endtask

  task automatic t_collide;
    int highs;
    write_cfg(9000, 2);
    repeat (20) @(negedge clk);
    off_req = 1'b1; cfg_we = 1'b1; cfg_tune = 16'd111; cfg_sel = 3'd5;
    @(negedge clk);
    off_req = 1'b0; cfg_we = 1'b0;
    chk(rd_tune == 9000, "R7", "tune after collision", rd_tune, 9000);
    chk(rd_sel == 2, "R7", "sel after collision", rd_sel, 2);
    chk(!rd_running, "R7", "running after collision", rd_running, 0);
    highs = 0;
    repeat (100) begin
      @(negedge clk);
      if (wave_pins != '0) highs++;
    end
    chk(highs == 0, "R7", "high samples after collision", highs, 0);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_tune = '0; cfg_sel = '0;
    off_req = 1'b0; pin_clk_mode = 4'b0101;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_freq(1000, 0, 4096);
    t_freq(32768, 0, 2048);
    t_freq(12345, 3, 8192);
    t_freq(20000, 7, 65536);
    t_freq(1, 0, 4096);
    t_zero();
    t_rewrite();
    t_off();
    t_freq(7000, 1, 4096);   // resume after off needs only a write
    t_collide();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule